// File: doc/BRIEF.md
# Single-Step Clock Enable with Boot Bypass

This block produces the clock enable that paces a small processor. While the processor's memory is still loading after reset, the enable is held high on every cycle, so the processor runs at the full system clock rate. When the loader reports completion on a one-cycle overflow flag, the block latches that event. From then on it raises the enable for exactly one system clock cycle each time an operator presses a push-button, so a program can be walked through one step at a time.

The button is brought into the clock domain by a synchronizer. After that, a two-state press tracker turns each released-to-pressed transition into a single pulse. Holding the button down for any length of time produces only that one pulse, and the tracker wants a release before it will accept a new press. The boot latch is sticky: once set, it stays set until reset.

Top module: `step_clock_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, the boot latch is cleared and the press tracker returns to its released state. After that edge `step_en` reads 1.
- R2: Before any overflow has been latched, `step_en` is 1 on every cycle, whatever `button_in` does.
- R3: A 1 on `boot_ovf` sampled at a clock edge switches the block to step mode from that edge onward.
- R4: Once step mode is entered, it persists after `boot_ovf` returns to 0, until the next reset.
- R5: In step mode, `step_en` is 0 except for one-cycle pulses. `button_in` passes through a 2-stage synchronizer. If `button_in` is sampled 1 at edge t and was sampled 0 at edge t-1, `step_en` is 1 for exactly the cycle that follows edge t+2.
- R6: Holding the button for any number of cycles yields a single pulse. A further pulse needs `button_in` to be sampled 0 at least once and then 1 again.
- R7: If the button is already held when step mode begins, no pulse appears until the button has been released and pressed again.
- R8: Reset applied while in step mode returns the block to boot mode (R2 behaviour).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| button_in | input | 1 | Raw push-button level, active high, asynchronous |
| boot_ovf | input | 1 | Loader completion flag, active high |
| step_en | output | 1 | Processor clock enable |

## Verification
On every cycle, the assertions check four things: `step_en` is high while no overflow is latched, the latch sets after an overflow and stays set, and a step pulse never lasts two cycles. What the scenarios alone can show is the count and placement of the pulses: one per press with the right latency, none for a held button, none for a press left over from boot, and the return to boot mode on reset. The bench compares these against a latency model over long random button runs mixed with directed cases.

// File: rtl/step_pkg.sv
// Shared types for the single-step clock enable.
// Assumes: nothing beyond a synchronous design style.
package step_pkg;
    typedef enum logic {
        ST_RELEASED = 1'b0,
        ST_HELD     = 1'b1
    } press_state_t;
endpackage

// File: rtl/btn_sync.sv
// Level synchronizer for an asynchronous button input.
// Assumes: STAGES >= 2; reset clears the chain to the released level.
module btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/press_stepper.sv
// Turns each released-to-pressed transition of a synchronized button
// into one registered pulse of a single clock cycle.
// Assumes: btn_s is already in the clk domain.
module press_stepper
    import step_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic btn_s,
    output logic pulse
);
    press_state_t state_q;
    logic         pulse_q;

    // Track whether the button is currently held.
    always_ff @(posedge clk) begin
        if (!rst_n)     state_q <= ST_RELEASED;
        else if (btn_s) state_q <= ST_HELD;
        else            state_q <= ST_RELEASED;
    end

    // Fire once on the first sampled pressed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= btn_s && (state_q == ST_RELEASED);
    end

    assign pulse = pulse_q;

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
endmodule

// File: rtl/boot_latch.sv
// Sticky record that the boot loader has finished.
// Assumes: set input is synchronous to clk.
module boot_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_in,
    output logic done
);
    logic done_q;

    // Set on overflow, hold until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= done_q | set_in;
    end

    assign done = done_q;

    // R3
    ovf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_in |=> done_q);
    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q);
endmodule

// File: rtl/step_clock_gate.sv
// Processor clock enable: always on during boot, one pulse per button
// press afterwards.
// Assumes: button_in is asynchronous; boot_ovf is synchronous to clk.
module step_clock_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic button_in,
    input  logic boot_ovf,
    output logic step_en
);
    logic btn_s;
    logic press_pulse;
    logic booted;

    btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (button_in),
        .dout  (btn_s)
    );

    press_stepper u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .btn_s (btn_s),
        .pulse (press_pulse)
    );

    boot_latch u_boot (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_in (boot_ovf),
        .done   (booted)
    );

    // Select free-running enable during boot, button pulses after.
    always_comb begin
        if (booted) step_en = press_pulse;
        else        step_en = 1'b1;
    end

    // R2
    boot_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !booted |-> step_en);
endmodule

// File: tb/sim_step_clock_gate.sv
`timescale 1ns/1ps
module sim_step_clock_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic button_in = 1'b0;
    logic boot_ovf = 1'b0;
    logic step_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model state: last four sampled button levels, boot flag
    logic h1 = 1'b0, h2 = 1'b0, h3 = 1'b0, h4 = 1'b0;
    logic m_boot = 1'b0;

    always #2.5 clk = ~clk;

    step_clock_gate u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .button_in (button_in),
        .boot_ovf  (boot_ovf),
        .step_en   (step_en)
    );

    function automatic logic expect_en(logic bt, logic b2, logic b3);
        // R5: pulse one cycle after edge t+2 for a rise sampled at edge t
        if (!bt) return 1'b1;
        return b2 & ~b3;
    endfunction

    task automatic check(string tag);
        logic e;
        e = expect_en(m_boot, h3, h4);
        checks++;
        if (step_en !== e) begin
            fails++;
            $display("FAIL %s at %0t: step_en=%b expected %b", tag, $time, step_en, e);
        end
    endtask

    // drive at negedge, model at posedge, check at next negedge
    task automatic cyc(logic b, logic o, logic r, string tag);
        button_in = b;
        boot_ovf  = o;
        rst_n     = r;
        @(posedge clk);
        if (!r) begin
            h1 = 0; h2 = 0; h3 = 0; h4 = 0; m_boot = 0;
        end else begin
            h4 = h3; h3 = h2; h2 = h1; h1 = b;
            m_boot = m_boot | o;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        // R1: reset state
        cyc(0, 0, 0, "R1");
        cyc(0, 0, 0, "R1");
        // R2: button toggling in boot mode
        for (int i = 0; i < 12; i++) cyc(i[1], 0, 1, "R2");
        cyc(0, 0, 1, "R2");
        cyc(0, 0, 1, "R2");
        cyc(0, 0, 1, "R2");
        // R3: overflow pulse enters step mode
        cyc(0, 1, 1, "R3");
        // R4: stays in step mode after flag drops
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, "R4");
        // R5: a short press, one pulse
        cyc(1, 0, 1, "R5");
        for (int i = 0; i < 6; i++) cyc(0, 0, 1, "R5");
        // R6: long hold, then single-cycle release and re-press
        for (int i = 0; i < 20; i++) cyc(1, 0, 1, "R6");
        cyc(0, 0, 1, "R6");
        for (int i = 0; i < 6; i++) cyc(1, 0, 1, "R6");
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, "R6");
        // R8: reset in step mode returns to boot mode
        cyc(0, 0, 0, "R8");
        for (int i = 0; i < 4; i++) cyc(i[0], 0, 1, "R8");
        // R7: button held across boot completion
        for (int i = 0; i < 5; i++) cyc(1, 0, 1, "R7");
        cyc(1, 1, 1, "R7");
        for (int i = 0; i < 8; i++) cyc(1, 0, 1, "R7");
        cyc(0, 0, 1, "R7");
        for (int i = 0; i < 5; i++) cyc(1, 0, 1, "R7");
        // random runs of button levels, rare overflow and reset
        for (int i = 0; i < 3000; i++) begin
            logic b, o, r;
            b = ($urandom % 4) != 0 ? h1 : ~h1;
            o = ($urandom % 200) == 0;
            r = ($urandom % 500) != 0;
            cyc(b, o, r, m_boot ? "R6" : "R2");
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule